// File: doc/BRIEF.md
# Crossbar VOQ Matching Scheduler

This block decides, once per timeslot, which inputs of an N-by-N crossbar connect to which outputs. Each input keeps a separate logical queue for every output. It reports the non-empty ones as one row of an N-by-N request matrix. A pulse on `slot_start` samples the matrix. The scheduler then runs a chain of request-grant-accept rounds in a single cycle. In each round, every free output grants one requesting free input, chosen round-robin from that output's grant pointer. Every input then accepts one of its grants, chosen round-robin from that input's accept pointer. Each round works only on the inputs and outputs that earlier rounds left free.

The result is registered on the clock edge that samples `slot_start`. It appears in three forms. `xbar_sel` gives one one-hot column select per output. `match_valid` has one bit per input. `deq` is a one-cycle strobe that names the queue to pop at each matched input. The selects and valid bits hold their values until the next slot. The grant and accept pointers move only on matches made in the first round. Each moves to one past its matched partner.

There is no stream port. Requests describe queue occupancy, not data, so there is no back-pressure. A `slot_start` may arrive on any cycle, including back-to-back cycles.

Top module: `voq_match_sched`

## Requirements
- R1: After every slot, each input is connected to at most one output, and `match_valid[i]` is high exactly when input i is connected.
- R2: After every slot, each output column of `xbar_sel` (bits o*N .. o*N+N-1, where bit o*N+i selects input i) is zero or one-hot.
- R3: A connection from input i to output o is made only if request bit `req[i*N+o]` was set when `slot_start` was sampled.
- R4: The match is maximal. No requested pair may have both its input and its output left unmatched.
- R5: A busy output never blocks an input. An input that loses one output but requests a free output is still matched.
- R6: `deq` (bit i*N+o means pop queue o at input i) equals the new match for exactly the one cycle after `slot_start`. At all other times it is zero.
- R7: `xbar_sel` and `match_valid` stay unchanged between slots, whatever `req` does.
- R8: After reset, all pointers are 0. An output grants the first requesting input at or after its pointer, wrapping around. An input accepts the first granting output at or after its pointer, wrapping around. A first-round match sets the output's pointer to one past the input and the input's pointer to one past the output. With every input requesting only output 0, successive slots serve inputs 0, 1, 2, 3, 0.
- R9: An all-zero request matrix gives an empty match and no `deq` bits.
- R10: While reset is held and right after it, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| slot_start | input | 1 | Sample `req` and compute a new match |
| req | input | N*N | Request matrix, bit i*N+o: input i holds cells for output o |
| match_valid | output | N | Input i is connected in the current slot |
| xbar_sel | output | N*N | Column selects, bit o*N+i: output o takes input i |
| deq | output | N*N | One-cycle dequeue strobe, bit i*N+o: pop queue o at input i |

## Verification
The assertions check the structural rules on every cycle. These are: one partner per input and per output, connections only on sampled requests, maximality against the sampled matrix, the single-cycle dequeue strobe, and selects that hold between slots. The round-robin order is a different matter. Pointer movement limited to first-round matches, service rotating across contending inputs, and the exact pairing produced under full load all depend on the history of earlier slots. Only the bench's directed slot sequences show these, by comparing against hand-derived pairings.

// File: rtl/voq_pkg.sv
package voq_pkg;
  // Index one past idx, wrapping at n.
  function automatic int wrap_next(input int idx, input int n);
    return (idx + 1) % n;
  endfunction
endpackage

// File: rtl/voq_rr_arb.sv
module voq_rr_arb #(
  parameter int N = 4,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] req,
  input  logic [W-1:0] ptr,
  output logic [N-1:0] gnt
);
  always_comb begin
    logic found;
    gnt   = '0;
    found = 1'b0;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = (int'(ptr) + k) % N;
      if (!found && req[idx]) begin
        gnt[idx] = 1'b1;
        found    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/voq_rga_iter.sv
module voq_rga_iter #(
  parameter int N = 4,
  localparam int W = $clog2(N)
) (
  input  logic [N*N-1:0] req,
  input  logic [N-1:0]   in_free,
  input  logic [N-1:0]   out_free,
  input  logic [N*W-1:0] gptr,
  input  logic [N*W-1:0] aptr,
  output logic [N*N-1:0] acc
);
  logic [N-1:0] col_req [N];  // [o][i]
  logic [N-1:0] col_gnt [N];  // [o][i]
  logic [N-1:0] row_gnt [N];  // [i][o]
  logic [N-1:0] row_acc [N];  // [i][o]

  for (genvar o = 0; o < N; o++) begin : g_out
    for (genvar i = 0; i < N; i++) begin : g_in
      assign col_req[o][i] = req[i*N+o] & in_free[i] & out_free[o];
      assign row_gnt[i][o] = col_gnt[o][i];
    end
    voq_rr_arb #(.N(N)) u_grant (
      .req(col_req[o]),
      .ptr(gptr[o*W +: W]),
      .gnt(col_gnt[o])
    );
  end

  for (genvar i = 0; i < N; i++) begin : g_acc
    voq_rr_arb #(.N(N)) u_accept (
      .req(row_gnt[i]),
      .ptr(aptr[i*W +: W]),
      .gnt(row_acc[i])
    );
    assign acc[i*N +: N] = row_acc[i];
  end
endmodule

// File: rtl/voq_match_sched.sv
module voq_match_sched #(
  parameter int N     = 4,
  parameter int ITERS = N,
  localparam int W    = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         slot_start,
  input  logic [N*N-1:0] req,
  output logic [N-1:0]   match_valid,
  output logic [N*N-1:0] xbar_sel,
  output logic [N*N-1:0] deq
);
  import voq_pkg::*;

  logic [W-1:0]   gptr_q [N];
  logic [W-1:0]   aptr_q [N];
  logic [N*W-1:0] gptr_flat, aptr_flat;

  logic [N*N-1:0] acc [ITERS];
  logic [N*N-1:0] cum [ITERS+1];
  logic [N-1:0]   in_free  [ITERS];
  logic [N-1:0]   out_free [ITERS];

  logic [N*N-1:0] sel_q, deq_q;
  logic [N-1:0]   valid_q;

  function automatic logic col_any(input logic [N*N-1:0] m, input int o);
    logic r;
    r = 1'b0;
    for (int i = 0; i < N; i++) r = r | m[i*N+o];
    return r;
  endfunction

  for (genvar p = 0; p < N; p++) begin : g_flat
    assign gptr_flat[p*W +: W] = gptr_q[p];
    assign aptr_flat[p*W +: W] = aptr_q[p];
  end

  assign cum[0] = '0;
  for (genvar k = 0; k < ITERS; k++) begin : g_iter
    for (genvar p = 0; p < N; p++) begin : g_free
      assign in_free[k][p]  = ~|cum[k][p*N +: N];
      assign out_free[k][p] = ~col_any(cum[k], p);
    end
    voq_rga_iter #(.N(N)) u_iter (
      .req     (req),
      .in_free (in_free[k]),
      .out_free(out_free[k]),
      .gptr    (gptr_flat),
      .aptr    (aptr_flat),
      .acc     (acc[k])
    );
    assign cum[k+1] = cum[k] | acc[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < N; p++) begin
        gptr_q[p] <= '0;
        aptr_q[p] <= '0;
      end
    end else if (slot_start) begin
      for (int i = 0; i < N; i++) begin
        for (int o = 0; o < N; o++) begin
          if (acc[0][i*N+o]) begin
            gptr_q[o] <= W'(wrap_next(i, N));
            aptr_q[i] <= W'(wrap_next(o, N));
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= '0;
      deq_q   <= '0;
      valid_q <= '0;
    end else if (slot_start) begin
      deq_q <= cum[ITERS];
      for (int i = 0; i < N; i++) begin
        valid_q[i] <= |cum[ITERS][i*N +: N];
        for (int o = 0; o < N; o++) sel_q[o*N+i] <= cum[ITERS][i*N+o];
      end
    end else begin
      deq_q <= '0;
    end
  end

  assign match_valid = valid_q;
  assign xbar_sel    = sel_q;
  assign deq         = deq_q;
endmodule

// File: rtl/voq_sched_checker.sv
module voq_sched_checker #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         slot_start,
  input logic [N*N-1:0] req,
  input logic [N-1:0]   match_valid,
  input logic [N*N-1:0] xbar_sel,
  input logic [N*N-1:0] deq
);
  logic [N*N-1:0] tr;      // bit i*N+o
  logic [N*N-1:0] req_q;
  logic [N*N-1:0] viol;

  for (genvar i = 0; i < N; i++) begin : g_tr
    for (genvar o = 0; o < N; o++) begin : g_o
      assign tr[i*N+o] = xbar_sel[o*N+i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) req_q <= '0;
    else if (slot_start) req_q <= req;
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      for (int o = 0; o < N; o++) begin
        viol[i*N+o] = req_q[i*N+o] & ~|tr[i*N +: N] & ~|xbar_sel[o*N +: N];
      end
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_row
    p_row_onehot_r1: assert property (@(posedge clk) disable iff (rst)
      $onehot0(tr[i*N +: N]));
    p_valid_r1: assert property (@(posedge clk) disable iff (rst)
      match_valid[i] == (|tr[i*N +: N]));
    p_col_onehot_r2: assert property (@(posedge clk) disable iff (rst)
      $onehot0(xbar_sel[i*N +: N]));
  end

  p_requested_r3: assert property (@(posedge clk) disable iff (rst)
    (tr & ~req_q) == '0);
  p_maximal_r4: assert property (@(posedge clk) disable iff (rst)
    viol == '0);
  p_deq_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !slot_start |=> deq == '0);
  p_deq_match_r6: assert property (@(posedge clk) disable iff (rst)
    slot_start |=> deq == tr);
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !slot_start |=> ($stable(xbar_sel) && $stable(match_valid)));
endmodule

bind voq_match_sched voq_sched_checker #(.N(N)) u_chk (.*);

// File: tb/tb_voq_match_sched.sv
`timescale 1ns/1ps
module tb_voq_match_sched;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         slot_start = 1'b0;
  logic [N*N-1:0] req = '0;
  logic [N-1:0]   match_valid;
  logic [N*N-1:0] xbar_sel;
  logic [N*N-1:0] deq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  voq_match_sched #(.N(N)) dut (
    .clk(clk), .rst(rst), .slot_start(slot_start), .req(req),
    .match_valid(match_valid), .xbar_sel(xbar_sel), .deq(deq)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [N*N-1:0] transp(input logic [N*N-1:0] s);
    logic [N*N-1:0] t;
    for (int i = 0; i < N; i++)
      for (int o = 0; o < N; o++) t[i*N+o] = s[o*N+i];
    return t;
  endfunction

  // pairs: expected output per input, -1 when unmatched
  function automatic logic [N*N-1:0] build(input int p0, input int p1, input int p2, input int p3);
    logic [N*N-1:0] m;
    int p [N];
    p[0] = p0; p[1] = p1; p[2] = p2; p[3] = p3;
    m = '0;
    for (int i = 0; i < N; i++) if (p[i] >= 0) m[i*N+p[i]] = 1'b1;
    return m;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; slot_start = 1'b0; req = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run_slot(input logic [N*N-1:0] r);
    @(negedge clk);
    req = r; slot_start = 1'b1;
    @(negedge clk);
    slot_start = 1'b0;
  endtask

  // Checks legality of the current (just-issued) slot against request r.
  task automatic legal(input logic [N*N-1:0] r);
    logic [N*N-1:0] m;
    logic [N*N-1:0] v;
    logic ok1, ok2;
    m = transp(xbar_sel);
    ok1 = 1'b1; ok2 = 1'b1;
    for (int i = 0; i < N; i++) begin
      if ($countones(m[i*N +: N]) > 1) ok1 = 1'b0;
      if (match_valid[i] != (|m[i*N +: N])) ok1 = 1'b0;
      if ($countones(xbar_sel[i*N +: N]) > 1) ok2 = 1'b0;
    end
    chk(ok1, "R1 one output per input", m, r);
    chk(ok2, "R2 one input per output", xbar_sel, r);
    chk((m & ~r) == '0, "R3 only requested pairs", m, r);
    v = '0;
    for (int i = 0; i < N; i++)
      for (int o = 0; o < N; o++)
        if (r[i*N+o] && !(|m[i*N +: N]) && !(|xbar_sel[o*N +: N])) v[i*N+o] = 1'b1;
    chk(v == '0, "R4 maximal match", v, 0);
    chk(deq == m, "R6 dequeue strobe equals match", deq, m);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(match_valid == '0 && xbar_sel == '0 && deq == '0, "R10 outputs zero in reset",
        {match_valid, xbar_sel[11:0]}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(match_valid == '0 && xbar_sel == '0 && deq == '0, "R10 outputs zero after reset",
        {match_valid, xbar_sel[11:0]}, 0);
  endtask

  task automatic t_empty();
    run_slot('0);
    chk(match_valid == '0 && xbar_sel == '0, "R9 empty request gives empty match", xbar_sel, 0);
    chk(deq == '0, "R9 no dequeue for empty request", deq, 0);
  endtask

  task automatic t_rotation();
    logic [N*N-1:0] r;
    int exp_in [5];
    do_reset();
    exp_in[0] = 0; exp_in[1] = 1; exp_in[2] = 2; exp_in[3] = 3; exp_in[4] = 0;
    r = '0;
    for (int i = 0; i < N; i++) r[i*N] = 1'b1;
    for (int s = 0; s < 5; s++) begin
      run_slot(r);
      legal(r);
      chk(xbar_sel[N-1:0] == (4'b1 << exp_in[s]), "R8 output 0 rotates over inputs",
          xbar_sel[N-1:0], 4'b1 << exp_in[s]);
    end
  endtask

  task automatic t_full();
    logic [N*N-1:0] r;
    do_reset();
    r = '1;
    run_slot(r);
    legal(r);
    chk(transp(xbar_sel) == build(0, 1, 2, 3), "R8 full load first slot identity",
        transp(xbar_sel), build(0, 1, 2, 3));
    run_slot(r);
    legal(r);
    chk(transp(xbar_sel) == build(1, 0, 2, 3), "R8 first-round pointer move only",
        transp(xbar_sel), build(1, 0, 2, 3));
  endtask

  task automatic t_hol();
    logic [N*N-1:0] r;
    do_reset();
    // input0 -> {o0}; input1 -> {o0,o1}; input2 -> {o0}
    r = '0;
    r[0*N+0] = 1'b1; r[1*N+0] = 1'b1; r[1*N+1] = 1'b1; r[2*N+0] = 1'b1;
    run_slot(r);
    legal(r);
    chk(match_valid[0] && match_valid[1], "R5 input 1 matched past busy output 0",
        match_valid, 4'b0011);
    chk(transp(xbar_sel) == build(0, 1, -1, -1), "R5 expected pairing",
        transp(xbar_sel), build(0, 1, -1, -1));
  endtask

  task automatic t_hold();
    logic [N*N-1:0] snap;
    logic [N-1:0]   vsnap;
    snap = xbar_sel; vsnap = match_valid;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      req = 16'hA5C3 ^ 16'(c);
      chk(deq == '0, "R6 dequeue lasts one cycle", deq, 0);
      chk(xbar_sel == snap && match_valid == vsnap, "R7 selects held between slots",
          xbar_sel, snap);
    end
  endtask

  task automatic t_mixed();
    logic [N*N-1:0] r;
    r = 16'b0110_1001_0011_1100;
    run_slot(r);
    legal(r);
    r = 16'b1000_0100_0010_0001;
    run_slot(r);
    legal(r);
    chk(match_valid == 4'hF, "R4 disjoint requests all matched", match_valid, 4'hF);
  endtask

  initial begin
    t_reset();
    t_empty();
    t_rotation();
    t_full();
    t_hol();
    t_hold();
    t_mixed();
    t_empty();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule